// File: doc/BRIEF.md
# Page Table Entry Legality Checker

This block walks a multi-level page table one entry at a time and judges each entry it fetches. The judgement is made by a combinational legality checker. Each entry is either illegal (the walk stops with a fault and a cause code), a pointer to the next table (the walk goes one level down), or a leaf (the walk stops and reports the physical page number it found). The checker takes the entry word and the walk configuration. The configuration gives the entry format, whether the walk belongs to a virtualized guest, the two memory-type enables (one from machine-level environment configuration, one from hypervisor-level environment configuration) and the enable for naturally-aligned power-of-two page entries.

A small sequencer around the checker handles the walk. On `walk_go` it latches the configuration and the root table page number. It issues a read request for each entry, holding the request until the memory side acknowledges with the entry word. It then evaluates the entry and either fetches the next level or ends the walk. Permission checks on the leaf and updates of accessed/dirty bits are left to the surrounding logic.

The sequencer has four states. `ST_IDLE` waits for `walk_go`. `ST_FETCH` holds `rd_req` until `rd_ack`. `ST_CHECK` evaluates the captured entry. `ST_DONE` pulses `walk_done` for one cycle. The transitions are:
- IDLE→FETCH on `walk_go`.
- FETCH→CHECK on `rd_ack`.
- CHECK→FETCH on a legal pointer above level zero (descend).
- CHECK→DONE on a fault, a leaf, or a pointer at level zero.
- DONE→IDLE unconditionally.

Entry bit positions, used by the checker and the bench:
- Valid is bit 0, read is bit 1, write is bit 2 and execute is bit 3.
- User is bit 4, accessed is bit 6 and dirty is bit 7. Bits 5, 8 and 9 are not examined.
- The page number starts at bit 10.
- In the 64-bit format, bits 60:54 are reserved, bits 62:61 form the memory-type field and bit 63 is the power-of-two page bit.

Top module: `pte_walk_seq`

## Requirements
- R1: After reset, and whenever `walk_busy` is low, `rd_req`, `walk_done`, `walk_fault`, `fault_code` and `leaf_ppn` are zero until a walk ends.
- R2: In the 64-bit format, any set bit in 60:54 ends the walk with fault code 1. This check has the highest priority.
- R3: In the 64-bit format, bit 63 set while the power-of-two enable is low faults with code 2. With the enable high, the bit alone does not fault.
- R4: A nonzero memory-type field (bits 62:61) faults with code 3 when the selected enable is low. A virtualized walk selects the hypervisor-level enable and any other walk selects the machine-level enable. The configuration is latched at `walk_go`.
- R5: A memory-type field of binary 11 faults with code 4 whatever the enables are, once the higher-priority checks pass.
- R6: A pointer entry (valid set, read, write and execute clear) faults with code 5 if user, accessed, dirty, the power-of-two bit or any memory-type bit is set.
- R7: A non-pointer entry with valid clear, or with write set and read clear, faults with code 6.
- R8: Any other entry is a leaf. The walk ends with `walk_fault` low and `fault_code` 0. `leaf_ppn` is bits 53:10 (64-bit) or bits 31:10 zero-extended (32-bit), and `leaf_level` is the level of that entry. On a fault `leaf_ppn` stays zero.
- R9: The first read is at the top level (2 for 64-bit, 1 for 32-bit) with `rd_ppn` equal to `root_ppn`. Each legal pointer causes a read one level lower with `rd_ppn` equal to the pointer's page number.
- R10: A legal pointer found at level 0 faults with code 7 and `leaf_level` 0.
- R11: In the 32-bit format, `rd_data[63:32]` is ignored. The reserved, power-of-two and memory-type checks do not apply.
- R12: `walk_done` is a one-cycle pulse. The results stay unchanged from that pulse until the next `walk_go`.
- R13: `rd_req` stays high until `rd_ack` is seen and drops in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| walk_go | input | 1 | Start a walk (accepted in ST_IDLE) |
| wide_mode | input | 1 | 1: 64-bit entries, three levels; 0: 32-bit entries, two levels |
| virt_walk | input | 1 | Walk belongs to a virtualized guest |
| menv_mt_en | input | 1 | Machine-level memory-type enable |
| henv_mt_en | input | 1 | Hypervisor-level memory-type enable |
| napot_en | input | 1 | Power-of-two page entries permitted |
| root_ppn | input | 44 | Page number of the top-level table |
| rd_req | output | 1 | Entry read request |
| rd_level | output | 2 | Level of the entry being read |
| rd_ppn | output | 44 | Page number of the table being read |
| rd_ack | input | 1 | Read acknowledge, qualifies rd_data |
| rd_data | input | 64 | Entry word |
| walk_busy | output | 1 | Walk in progress |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| walk_fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | Fault cause (0 none, 1 to 7 as in R2 to R10) |
| leaf_ppn | output | 44 | Page number from the leaf |
| leaf_level | output | 2 | Level at which the walk ended |

## Verification
The bench sweeps the valid, read, write and execute bits, the pointer attribute bits, the power-of-two bit, all four memory-type codes, every reserved bit position and all sixteen configuration combinations in the 64-bit format. It does the same for the 32-bit format, with junk placed in the upper word. A checker with the priority order wrong would report the wrong code on entries carrying several faults at once. One selecting the wrong enable would pass or fail memory-typed entries with `virt_walk` inverted. Since the bench flips the configuration inputs after `walk_go`, a sequencer that did not latch them would be caught too. Pointer chains to level zero, delayed acknowledges and result holding after `walk_done` are driven separately. These catch a walk that never ends, an off-by-one level, or a request dropped early.

// File: rtl/pte_walk_pkg.sv
package pte_walk_pkg;

    // Result of judging one entry
    typedef enum logic [1:0] {
        CK_FAULT   = 2'd0,
        CK_DESCEND = 2'd1,
        CK_LEAF    = 2'd2
    } ck_kind_e;

    // Fault cause codes, listed in decreasing check priority
    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_RSVD     = 3'd1,
        FC_NAPOT    = 3'd2,
        FC_MT_OFF   = 3'd3,
        FC_MT_BAD   = 3'd4,
        FC_PTR_ATTR = 3'd5,
        FC_ENCODE   = 3'd6,
        FC_DEPTH    = 3'd7
    } fcode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } wstate_e;

    // Low attribute bit positions (shared by both formats)
    localparam int unsigned B_V = 0;
    localparam int unsigned B_R = 1;
    localparam int unsigned B_W = 2;
    localparam int unsigned B_X = 3;
    localparam int unsigned B_U = 4;
    localparam int unsigned B_A = 6;
    localparam int unsigned B_D = 7;

endpackage

// File: rtl/pte_legal_chk.sv
module pte_legal_chk
    import pte_walk_pkg::*;
#(
    parameter int PTE_W     = 64,
    parameter int NARROW_W  = 32,
    parameter int PPN_SHIFT = 10,
    parameter int RSVD_LO   = 54,
    parameter int RSVD_W    = 7,
    parameter int MT_W      = 2
) (
    input  logic [PTE_W-1:0]            pte,
    input  logic                        wide,
    input  logic                        virt,
    input  logic                        menv_en,
    input  logic                        henv_en,
    input  logic                        napot_en,
    output ck_kind_e                    kind,
    output fcode_e                      code,
    output logic [RSVD_LO-PPN_SHIFT-1:0] ppn
);

    localparam int MT_LO     = RSVD_LO + RSVD_W;
    localparam int NAPOT_BIT = MT_LO + MT_W;
    localparam int PPN_W     = RSVD_LO - PPN_SHIFT;

    logic            rsvd_hit;
    logic            n_bit;
    logic [MT_W-1:0] mt;
    logic            mt_en;
    logic            is_ptr;
    logic            ptr_attr;
    logic            bad_enc;
    logic            unused_attr;

    assign unused_attr = ^{pte[5], pte[9:8]};

    always_comb begin
        rsvd_hit = wide & (|pte[RSVD_LO +: RSVD_W]);
        n_bit    = wide & pte[NAPOT_BIT];
        mt       = wide ? pte[MT_LO +: MT_W] : '0;
        mt_en    = virt ? henv_en : menv_en;
        is_ptr   = pte[B_V] & ~pte[B_R] & ~pte[B_W] & ~pte[B_X];
        ptr_attr = pte[B_U] | pte[B_A] | pte[B_D] | n_bit | (|mt);
        bad_enc  = ~pte[B_V] | (pte[B_W] & ~pte[B_R]);

        kind = CK_FAULT;
        code = FC_NONE;
        if (rsvd_hit) begin
            code = FC_RSVD;
        end else if (n_bit && !napot_en) begin
            code = FC_NAPOT;
        end else if ((|mt) && !mt_en) begin
            code = FC_MT_OFF;
        end else if (&mt) begin
            code = FC_MT_BAD;
        end else if (is_ptr) begin
            if (ptr_attr) code = FC_PTR_ATTR;
            else          kind = CK_DESCEND;
        end else if (bad_enc) begin
            code = FC_ENCODE;
        end else begin
            kind = CK_LEAF;
        end

        ppn = wide ? pte[RSVD_LO-1:PPN_SHIFT]
                   : PPN_W'(pte[NARROW_W-1:PPN_SHIFT]);
    end

endmodule

// File: rtl/pte_lvl_ctr.sv
module pte_lvl_ctr #(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LVL_W-1:0] load_val,
    input  logic             dec,
    output logic [LVL_W-1:0] lvl,
    output logic             at_zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= '0;
        end else if (load) begin
            lvl <= load_val;
        end else if (dec && (lvl != '0)) begin
            lvl <= lvl - 1'b1;
        end
    end

    assign at_zero = (lvl == '0);

endmodule

// File: rtl/pte_walk_seq.sv
module pte_walk_seq
    import pte_walk_pkg::*;
#(
    parameter int PTE_W         = 64,
    parameter int NARROW_W      = 32,
    parameter int PPN_SHIFT     = 10,
    parameter int RSVD_W        = 7,
    parameter int MT_W          = 2,
    parameter int WIDE_LEVELS   = 3,
    parameter int NARROW_LEVELS = 2,
    localparam int RSVD_LO      = PTE_W - 1 - MT_W - RSVD_W,
    localparam int PPN_W        = RSVD_LO - PPN_SHIFT,
    localparam int LVL_W        = $clog2(WIDE_LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             walk_go,
    input  logic             wide_mode,
    input  logic             virt_walk,
    input  logic             menv_mt_en,
    input  logic             henv_mt_en,
    input  logic             napot_en,
    input  logic [PPN_W-1:0] root_ppn,
    output logic             rd_req,
    output logic [LVL_W-1:0] rd_level,
    output logic [PPN_W-1:0] rd_ppn,
    input  logic             rd_ack,
    input  logic [PTE_W-1:0] rd_data,
    output logic             walk_busy,
    output logic             walk_done,
    output logic             walk_fault,
    output logic [2:0]       fault_code,
    output logic [PPN_W-1:0] leaf_ppn,
    output logic [LVL_W-1:0] leaf_level
);

    localparam logic [LVL_W-1:0] TOP_WIDE   = LVL_W'(WIDE_LEVELS - 1);
    localparam logic [LVL_W-1:0] TOP_NARROW = LVL_W'(NARROW_LEVELS - 1);

    wstate_e          state_q, state_d;

    // Latched walk configuration
    logic             wide_q, virt_q, men_q, hen_q, nap_q;
    logic [PTE_W-1:0] pte_q;
    logic [PPN_W-1:0] base_q;

    // Result registers
    logic             res_fault_q;
    fcode_e           res_code_q;
    logic [PPN_W-1:0] res_ppn_q;
    logic [LVL_W-1:0] res_lvl_q;

    ck_kind_e         chk_kind;
    fcode_e           chk_code;
    logic [PPN_W-1:0] chk_ppn;

    logic [LVL_W-1:0] lvl;
    logic             lvl_zero;
    logic             accept_go;
    logic             go_down;

    assign accept_go = (state_q == ST_IDLE) && walk_go;
    assign go_down   = (state_q == ST_CHECK) && (chk_kind == CK_DESCEND) && !lvl_zero;

    pte_legal_chk #(
        .PTE_W     (PTE_W),
        .NARROW_W  (NARROW_W),
        .PPN_SHIFT (PPN_SHIFT),
        .RSVD_LO   (RSVD_LO),
        .RSVD_W    (RSVD_W),
        .MT_W      (MT_W)
    ) u_legal (
        .pte      (pte_q),
        .wide     (wide_q),
        .virt     (virt_q),
        .menv_en  (men_q),
        .henv_en  (hen_q),
        .napot_en (nap_q),
        .kind     (chk_kind),
        .code     (chk_code),
        .ppn      (chk_ppn)
    );

    pte_lvl_ctr #(
        .LVL_W (LVL_W)
    ) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_go),
        .load_val (wide_mode ? TOP_WIDE : TOP_NARROW),
        .dec      (go_down),
        .lvl      (lvl),
        .at_zero  (lvl_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (walk_go) state_d = ST_FETCH;
            ST_FETCH: if (rd_ack)  state_d = ST_CHECK;
            ST_CHECK: state_d = go_down ? ST_FETCH : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        rd_req    = 1'b0;
        walk_done = 1'b0;
        walk_busy = 1'b1;
        unique case (state_q)
            ST_IDLE:  walk_busy = 1'b0;
            ST_FETCH: rd_req    = 1'b1;
            ST_CHECK: ;
            ST_DONE:  walk_done = 1'b1;
            default:  walk_busy = 1'b0;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q      <= 1'b0;
            virt_q      <= 1'b0;
            men_q       <= 1'b0;
            hen_q       <= 1'b0;
            nap_q       <= 1'b0;
            pte_q       <= '0;
            base_q      <= '0;
            res_fault_q <= 1'b0;
            res_code_q  <= FC_NONE;
            res_ppn_q   <= '0;
            res_lvl_q   <= '0;
        end else begin
            if (accept_go) begin
                wide_q      <= wide_mode;
                virt_q      <= virt_walk;
                men_q       <= menv_mt_en;
                hen_q       <= henv_mt_en;
                nap_q       <= napot_en;
                base_q      <= root_ppn;
                res_fault_q <= 1'b0;
                res_code_q  <= FC_NONE;
                res_ppn_q   <= '0;
                res_lvl_q   <= '0;
            end
            if ((state_q == ST_FETCH) && rd_ack) begin
                pte_q <= rd_data;
            end
            if (state_q == ST_CHECK) begin
                unique case (chk_kind)
                    CK_FAULT: begin
                        res_fault_q <= 1'b1;
                        res_code_q  <= chk_code;
                        res_lvl_q   <= lvl;
                    end
                    CK_DESCEND: begin
                        if (lvl_zero) begin
                            res_fault_q <= 1'b1;
                            res_code_q  <= FC_DEPTH;
                            res_lvl_q   <= lvl;
                        end else begin
                            base_q <= chk_ppn;
                        end
                    end
                    CK_LEAF: begin
                        res_ppn_q <= chk_ppn;
                        res_lvl_q <= lvl;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_level   = lvl;
    assign rd_ppn     = base_q;
    assign walk_fault = res_fault_q;
    assign fault_code = res_code_q;
    assign leaf_ppn   = res_ppn_q;
    assign leaf_level = res_lvl_q;

endmodule

// File: rtl/pte_walk_chk.sv
module pte_walk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       walk_go,
    input logic       walk_busy,
    input logic       rd_req,
    input logic       rd_ack,
    input logic       walk_done,
    input logic       walk_fault,
    input logic [2:0] fault_code
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_busy |-> (!rd_req && !walk_done));

    // R12
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_go && !walk_busy) |=> (walk_busy && rd_req));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    // R13
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> !rd_req);

    // R8
    leaf_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && !walk_fault) |-> (fault_code == 3'd0));

    // R2
    fault_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && walk_fault) |-> (fault_code != 3'd0));

endmodule

bind pte_walk_seq pte_walk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_go    (walk_go),
    .walk_busy  (walk_busy),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .walk_done  (walk_done),
    .walk_fault (walk_fault),
    .fault_code (fault_code)
);

// File: tb/pte_walk_seq_tb.sv
`timescale 1ns/1ps
module pte_walk_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_go = 1'b0;
    logic        wide_mode = 1'b0;
    logic        virt_walk = 1'b0;
    logic        menv_mt_en = 1'b0;
    logic        henv_mt_en = 1'b0;
    logic        napot_en = 1'b0;
    logic [43:0] root_ppn = '0;
    logic        rd_req;
    logic [1:0]  rd_level;
    logic [43:0] rd_ppn;
    logic        rd_ack = 1'b0;
    logic [63:0] rd_data = '0;
    logic        walk_busy, walk_done, walk_fault;
    logic [2:0]  fault_code;
    logic [43:0] leaf_ppn;
    logic [1:0]  leaf_level;

    int total = 0;
    int bad = 0;

    logic [63:0] mem [0:2];
    int          nfetch;
    int          req_cyc;
    logic [1:0]  seen_lvl [0:3];
    logic [43:0] seen_ppn [0:3];

    always #2.5 clk = ~clk;

    pte_walk_seq u_dut (
        .clk(clk), .rst_n(rst_n), .walk_go(walk_go), .wide_mode(wide_mode),
        .virt_walk(virt_walk), .menv_mt_en(menv_mt_en), .henv_mt_en(henv_mt_en),
        .napot_en(napot_en), .root_ppn(root_ppn), .rd_req(rd_req),
        .rd_level(rd_level), .rd_ppn(rd_ppn), .rd_ack(rd_ack), .rd_data(rd_data),
        .walk_busy(walk_busy), .walk_done(walk_done), .walk_fault(walk_fault),
        .fault_code(fault_code), .leaf_ppn(leaf_ppn), .leaf_level(leaf_level)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected judgement of one entry, from the requirement text.
    // kind: 0 fault, 1 pointer, 2 leaf
    function automatic void model(input logic [63:0] p, input bit wide,
                                  input bit virt, input bit men, input bit hen,
                                  input bit nap, output int kind, output int code,
                                  output logic [43:0] ppn);
        logic [6:0] rs;
        logic       n;
        logic [1:0] mt;
        bit         ptr;
        bit         pattr;
        bit         benc;
        rs    = wide ? p[60:54] : 7'd0;
        n     = wide ? p[63] : 1'b0;
        mt    = wide ? p[62:61] : 2'd0;
        ptr   = p[0] && !p[1] && !p[2] && !p[3];
        pattr = p[4] || p[6] || p[7] || n || (mt != 2'd0);
        benc  = !p[0] || (p[2] && !p[1]);
        ppn   = wide ? p[53:10] : {22'd0, p[31:10]};
        kind  = 0;
        code  = 0;
        if (rs != 0)                              code = 1;
        else if (n && !nap)                       code = 2;
        else if (mt != 0 && !(virt ? hen : men))  code = 3;
        else if (mt == 2'd3)                      code = 4;
        else if (ptr) begin
            if (pattr) code = 5;
            else       kind = 1;
        end
        else if (benc)                            code = 6;
        else                                      kind = 2;
    endfunction

    function automatic string tag_of(input int kind, input int code);
        if (kind == 1) return "R9";
        if (kind == 2) return "R8";
        case (code)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R10";
        endcase
    endfunction

    // Run one walk; the bench answers reads from mem[] after dly wait cycles.
    // Config inputs are inverted after walk_go to show they were latched (R4).
    task automatic run_walk(input bit wide, input bit virt, input bit men,
                            input bit hen, input bit nap, input logic [43:0] root,
                            input int dly, output bit got_done);
        int wait_n;
        got_done = 0;
        nfetch = 0;
        req_cyc = 0;
        wait_n = 0;
        @(negedge clk);
        wide_mode = wide; virt_walk = virt; menv_mt_en = men;
        henv_mt_en = hen; napot_en = nap; root_ppn = root;
        walk_go = 1'b1;
        @(negedge clk);
        walk_go = 1'b0;
        wide_mode = ~wide; virt_walk = ~virt; menv_mt_en = ~men;
        henv_mt_en = ~hen; napot_en = ~nap; root_ppn = ~root;
        for (int c = 0; c < 60; c++) begin
            if (walk_done) begin
                got_done = 1;
                break;
            end
            if (rd_req) begin
                req_cyc++;
                if (wait_n < dly) begin
                    rd_ack = 1'b0;
                    wait_n++;
                end else begin
                    wait_n = 0;
                    if (nfetch < 4) begin
                        seen_lvl[nfetch] = rd_level;
                        seen_ppn[nfetch] = rd_ppn;
                    end
                    nfetch++;
                    rd_ack = 1'b1;
                    rd_data = mem[rd_level];
                end
            end else begin
                rd_ack = 1'b0;
            end
            @(negedge clk);
        end
        rd_ack = 1'b0;
    endtask

    // One-step sweep item: entry p at the top level; pointer leads to leaf next.
    task automatic sweep_one(input logic [63:0] p, input bit wide, input bit virt,
                             input bit men, input bit hen, input bit nap,
                             input logic [63:0] next_leaf);
        int          kind, code;
        logic [43:0] ppn, exp_ppn, nppn;
        logic [1:0]  top, exp_lvl;
        bit          exp_f, ok, done;
        int          dk, dc;
        logic [43:0] root;
        top  = wide ? 2'd2 : 2'd1;
        root = 44'h5A5_A5A5_A5A ^ p[53:10];
        mem[0] = 64'd0; mem[1] = 64'd0; mem[2] = 64'd0;
        mem[top]        = p;
        mem[top - 2'd1] = next_leaf;
        model(p, wide, virt, men, hen, nap, kind, code, ppn);
        run_walk(wide, virt, men, hen, nap, root, 0, done);
        if (kind == 1) begin
            model(next_leaf, wide, virt, men, hen, nap, dk, dc, nppn);
            exp_f = 0; exp_ppn = nppn; exp_lvl = top - 2'd1;
        end else begin
            exp_f = (kind == 0); exp_ppn = (kind == 2) ? ppn : 44'd0; exp_lvl = top;
        end
        ok = done && (walk_fault == exp_f) && (fault_code == 3'(code))
             && (leaf_ppn == exp_ppn) && (leaf_level == exp_lvl)
             && (seen_lvl[0] == top) && (seen_ppn[0] == root)
             && (nfetch == ((kind == 1) ? 2 : 1));
        if (ok && kind == 1)
            ok = (seen_lvl[1] == top - 2'd1) && (seen_ppn[1] == ppn);
        check(ok, tag_of(kind, code),
              $sformatf("pte=%h wide=%0d cfg=%0d%0d%0d%0d fault/code/lvl/ppn",
                        p, wide, virt, men, hen, nap),
              {9'd0, walk_fault, fault_code, leaf_level, 5'd0, leaf_ppn},
              {9'd0, exp_f, 3'(code), exp_lvl, 5'd0, exp_ppn});
    endtask

    initial begin
        #950000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] p;
        logic [63:0] hold_snap;
        bit          done;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!rd_req && !walk_busy && !walk_done && !walk_fault
              && fault_code == 0 && leaf_ppn == 0, "R1", "reset outputs",
              {rd_req, walk_busy, walk_done, walk_fault, fault_code, leaf_ppn},
              64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !walk_busy && !walk_done, "R1", "idle after reset",
              {61'd0, rd_req, walk_busy, walk_done}, 64'd0);

        // 64-bit sweep: R2..R9
        for (int v4 = 0; v4 < 16; v4++)
        for (int uad = 0; uad < 4; uad++)
        for (int nb = 0; nb < 2; nb++)
        for (int mt = 0; mt < 4; mt++)
        for (int rv = 0; rv < 2; rv++)
        for (int cfg = 0; cfg < 16; cfg++) begin
            p = 64'd0;
            p[3:0]   = 4'(v4);
            if (uad == 1) p[4] = 1'b1;
            if (uad == 2) p[6] = 1'b1;
            if (uad == 3) p[7] = 1'b1;
            p[63]    = 1'(nb);
            p[62:61] = 2'(mt);
            if (rv != 0) p[54 + ((v4 + cfg + mt) % 7)] = 1'b1;
            p[53:10] = 44'hABC_DEF0_1234 + 44'(cfg * 977 + v4 * 31 + mt);
            p[8]     = cfg[0];
            p[5]     = cfg[1];
            sweep_one(p, 1'b1, cfg[3], cfg[2], cfg[1], cfg[0],
                      {10'd0, 44'h123_4567_89A, 10'h00B});
        end

        // 32-bit sweep with junk in the upper word: R11, R6, R7, R8, R9
        for (int v4 = 0; v4 < 16; v4++)
        for (int uad = 0; uad < 4; uad++)
        for (int junk = 0; junk < 4; junk++)
        for (int cfg = 0; cfg < 16; cfg++) begin
            p = 64'd0;
            p[3:0] = 4'(v4);
            if (uad == 1) p[4] = 1'b1;
            if (uad == 2) p[6] = 1'b1;
            if (uad == 3) p[7] = 1'b1;
            p[31:10] = 22'h2A_5C3D + 22'(cfg * 13 + v4);
            if (junk[0]) p[63:54] = 10'h3FF;
            if (junk[1]) p[62:61] = 2'b11;
            sweep_one(p, 1'b0, cfg[3], cfg[2], cfg[1], cfg[0],
                      {32'hFFFF_FFFF, 22'h1F_0E0D, 10'h00F});
        end

        // R10 pointer chain to level 0, 64-bit: levels 2,1,0
        mem[2] = {10'd0, 44'h111_1111_111, 10'h001};
        mem[1] = {10'd0, 44'h222_2222_222, 10'h001};
        mem[0] = {10'd0, 44'h333_3333_333, 10'h001};
        run_walk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 44'h0AB_CDEF_012, 0, done);
        check(done && walk_fault && fault_code == 3'd7 && leaf_level == 2'd0
              && leaf_ppn == 44'd0, "R10", "64-bit pointer at level 0",
              {59'd0, walk_fault, fault_code, leaf_level[0]}, {59'd0, 1'b1, 3'd7, 1'b0});
        check(nfetch == 3 && seen_lvl[0] == 2 && seen_lvl[1] == 1 && seen_lvl[2] == 0,
              "R9", "64-bit level sequence",
              {32'(nfetch), 26'd0, seen_lvl[0], seen_lvl[1], seen_lvl[2]},
              {32'd3, 26'd0, 2'd2, 2'd1, 2'd0});
        check(seen_ppn[0] == 44'h0AB_CDEF_012 && seen_ppn[1] == 44'h111_1111_111
              && seen_ppn[2] == 44'h222_2222_222, "R9", "64-bit table chain",
              {20'd0, seen_ppn[2]}, {20'd0, 44'h222_2222_222});

        // R10 pointer chain to level 0, 32-bit: levels 1,0
        mem[1] = {32'hDEAD_BEEF, 22'h0A_BCDE, 10'h001};
        mem[0] = {32'h0000_0000, 22'h01_2345, 10'h001};
        run_walk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 44'h000_0012_345, 0, done);
        check(done && walk_fault && fault_code == 3'd7 && leaf_level == 2'd0
              && nfetch == 2 && seen_lvl[0] == 1 && seen_ppn[1] == 44'h000_000A_BCDE,
              "R10", "32-bit pointer at level 0",
              {20'd0, seen_ppn[1]}, {20'd0, 44'h000_000A_BCDE});

        // R13 delayed acknowledge: request held for dly+1 sampled cycles
        mem[2] = {10'd0, 44'h0C0_FFEE_000, 10'h00B};
        run_walk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 44'd7, 3, done);
        check(done && req_cyc == 4 && !walk_fault && leaf_ppn == 44'h0C0_FFEE_000
              && leaf_level == 2'd2, "R13", "request held through ack delay",
              64'(req_cyc), 64'd4);

        // R12 done is a pulse and results hold until next go
        hold_snap = {walk_fault, fault_code, leaf_level, 14'd0, leaf_ppn};
        repeat (3) @(negedge clk);
        check(!walk_done && !walk_busy
              && {walk_fault, fault_code, leaf_level, 14'd0, leaf_ppn} == hold_snap,
              "R12", "results held after done",
              {walk_fault, fault_code, leaf_level, 14'd0, leaf_ppn}, hold_snap);

        // R3 power-of-two bit allowed with enable on a leaf
        mem[2] = {1'b1, 9'd0, 44'h00F_0000_001, 10'h003};
        run_walk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 44'd1, 0, done);
        check(done && !walk_fault && leaf_ppn == 44'h00F_0000_001, "R3",
              "power-of-two leaf accepted with enable", {63'd0, walk_fault}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule